// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

The block tabulates a second-order polynomial one point at a time using nothing but adders. It keeps a chain of three accumulators: the current function value, the running first difference and a fixed second difference. Each step first adds the second difference into the first difference. It then adds that fresh first difference into the function value. No multiplier is involved.

A caller seeds the chain with a one-cycle load pulse that carries the starting value, the starting first difference and the second difference. This also rewinds the point index to zero. Each later step pulse advances the index by one and presents the next value together with a one-cycle valid strobe. Additions wrap modulo 2^W. Any carry out of the top bit raises a sticky overflow flag, which stays set until the next load.

Top module: `diff_tab`

## Requirements
- R1: While reset is asserted and after its release, with no load or step yet, val_o, idx_o, valid_o and ovf_o are all 0.
- R2: One cycle after load_i is high, val_o equals the f0_i presented with it, idx_o is 0 and valid_o is 1.
- R3: One cycle after step_i is high with load_i low, the first difference becomes d1+d2 and val_o becomes the previous val_o plus that new first difference. In the same cycle idx_o increments by one and valid_o is 1.
- R4: In a cycle with neither load_i nor step_i, valid_o is 0 one cycle later, and val_o and idx_o keep their values.
- R5: When load_i and step_i are high in the same cycle, the load wins. val_o takes f0_i, idx_o takes 0, and no step is applied.
- R6: A step in which either addition carries out of bit W-1 sets ovf_o one cycle later. The results wrap modulo 2^W. ovf_o then stays 1 across further steps and idle cycles.
- R7: A load clears ovf_o one cycle later.
- R8: Seeded with f0=41, d1=0, d2=2, successive steps give n*n+n+41 for n = 1..1000, with idx_o equal to n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Seed pulse; takes priority over step_i |
| f0_i | input | W | Starting function value |
| d1_i | input | W | Starting first difference |
| d2_i | input | W | Constant second difference |
| step_i | input | 1 | Advance one point |
| val_o | output | W | Current function value |
| valid_o | output | 1 | One-cycle strobe after each load or step |
| idx_o | output | IDX_W | Current point index n |
| ovf_o | output | 1 | Sticky carry-out flag |

## Verification
Every result is registered once. The value, the index, the valid strobe and the overflow flag are all due exactly one clock after the load or step that caused them. The bench drives inputs on the falling edge and holds a pulse for one full cycle. It deasserts the pulse at the next falling edge and samples all outputs at that same point, which falls half a cycle after the rising edge that registered the result. Hold and sticky-flag checks sample again after idle cycles, before any further stimulus is applied.

// File: rtl/diff_tab_pkg.sv
package diff_tab_pkg;
  localparam int unsigned ORDER = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } op_e;
endpackage

// File: rtl/diff_tab_add.sv
module diff_tab_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o
);
  logic [W:0] full;

  assign full  = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = full[W-1:0];
  assign cy_o  = full[W];
endmodule

// File: rtl/diff_tab_idx.sv
module diff_tab_idx #(
  parameter int unsigned IDX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] cnt_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/diff_tab_ctrl.sv
module diff_tab_ctrl
  import diff_tab_pkg::*;
#(
  parameter int unsigned NCY = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [NCY-1:0] cy_i,
  output logic           do_load_o,
  output logic           do_step_o,
  output logic           valid_o,
  output logic           ovf_o
);
  op_e  op;
  logic valid_q, ovf_q;

  always_comb begin
    if (load_i)      op = OP_LOAD;
    else if (step_i) op = OP_STEP;
    else             op = OP_IDLE;
  end

  assign do_load_o = (op == OP_LOAD);
  assign do_step_o = (op == OP_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= (op != OP_IDLE);
      case (op)
        OP_LOAD: ovf_q <= 1'b0;
        OP_STEP: ovf_q <= ovf_q | (|cy_i);
        default: ovf_q <= ovf_q;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/diff_tab.sv
module diff_tab
  import diff_tab_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     f0_i,
  input  logic [W-1:0]     d1_i,
  input  logic [W-1:0]     d2_i,
  input  logic             step_i,
  output logic [W-1:0]     val_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ovf_o
);
  localparam int unsigned NREG = ORDER + 1;

  logic [W-1:0]     acc_q [NREG];
  logic [W-1:0]     seed  [NREG];
  logic [W-1:0]     chain [NREG];
  logic [ORDER-1:0] cy;
  logic             do_load, do_step;

  assign seed[0] = f0_i;
  assign seed[1] = d1_i;
  assign seed[2] = d2_i;

  // chain[k] is the post-step value of acc k; the top order term stays constant
  assign chain[ORDER] = acc_q[ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    diff_tab_add #(.W(W)) u_add (
      .a_i  (acc_q[k]),
      .b_i  (chain[k+1]),
      .sum_o(chain[k]),
      .cy_o (cy[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) acc_q[k] <= '0;
    end else if (do_load) begin
      for (int k = 0; k < NREG; k++) acc_q[k] <= seed[k];
    end else if (do_step) begin
      for (int k = 0; k < ORDER; k++) acc_q[k] <= chain[k];
    end
  end

  diff_tab_ctrl #(.NCY(ORDER)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .step_i   (step_i),
    .cy_i     (cy),
    .do_load_o(do_load),
    .do_step_o(do_step),
    .valid_o  (valid_o),
    .ovf_o    (ovf_o)
  );

  diff_tab_idx #(.IDX_W(IDX_W)) u_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (do_load),
    .inc_i (do_step),
    .cnt_o (idx_o)
  );

  assign val_o = acc_q[0];
endmodule

// File: rtl/diff_tab_chk.sv
module diff_tab_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             step_i,
  input logic [W-1:0]     f0_i,
  input logic [W-1:0]     val_o,
  input logic             valid_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             ovf_o
);
  AST_LOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (val_o == $past(f0_i)) && (idx_o == '0) && valid_o); // R2
  AST_STEP_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (idx_o == $past(idx_o) + 1'b1) && valid_o); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> !valid_o && $stable(val_o) && $stable(idx_o)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !load_i) |=> ovf_o); // R6
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ovf_o); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(step_i) && !$past(load_i)); // R6
endmodule

bind diff_tab diff_tab_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .step_i (step_i),
  .f0_i   (f0_i),
  .val_o  (val_o),
  .valid_o(valid_o),
  .idx_o  (idx_o),
  .ovf_o  (ovf_o)
);

// File: tb/diff_tab_bench.sv
module diff_tab_bench;
  localparam int unsigned W     = 32;
  localparam int unsigned IDX_W = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_i = 1'b0;
  logic             step_i = 1'b0;
  logic [W-1:0]     f0_i = '0, d1_i = '0, d2_i = '0;
  logic [W-1:0]     val_o;
  logic             valid_o;
  logic [IDX_W-1:0] idx_o;
  logic             ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  diff_tab #(.W(W), .IDX_W(IDX_W)) u_diff_tab (.*);

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] f0, d1, d2);
    @(negedge clk_i);
    load_i = 1'b1; f0_i = f0; d1_i = d1; d2_i = d2;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "val", val_o, 0);
    chk("R1", "idx", idx_o, 0);
    chk("R1", "valid", valid_o, 0);
    chk("R1", "ovf", ovf_o, 0);
  endtask

  task automatic t_load();
    do_load(32'd1234, 32'd7, 32'd3);
    chk("R2", "val", val_o, 1234);
    chk("R2", "idx", idx_o, 0);
    chk("R2", "valid", valid_o, 1);
    do_step();
    chk("R3", "val", val_o, 1234 + 10);
    chk("R3", "idx", idx_o, 1);
    chk("R3", "valid", valid_o, 1);
    do_step();
    chk("R3", "val2", val_o, 1244 + 13);
    chk("R3", "idx2", idx_o, 2);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    chk("R4", "valid", valid_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R4", "val", val_o, 1257);
    chk("R4", "idx", idx_o, 2);
    chk("R4", "valid2", valid_o, 0);
  endtask

  task automatic t_priority();
    @(negedge clk_i);
    load_i = 1'b1; step_i = 1'b1; f0_i = 32'd5; d1_i = 32'd100; d2_i = 32'd1;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    chk("R5", "val", val_o, 5);
    chk("R5", "idx", idx_o, 0);
    do_step();
    chk("R5", "val_after", val_o, 5 + 101);
  endtask

  task automatic t_overflow();
    do_load(32'hFFFF_FFF0, 32'd0, 32'h10);
    chk("R7", "ovf_clr", ovf_o, 0);
    do_step();
    chk("R6", "wrap_val", val_o, 0);
    chk("R6", "ovf_f", ovf_o, 1);
    do_step();
    chk("R6", "sticky_step", ovf_o, 1);
    repeat (2) @(negedge clk_i);
    chk("R6", "sticky_idle", ovf_o, 1);
    do_load(32'd0, 32'hFFFF_FFFF, 32'd1);
    chk("R7", "ovf_load", ovf_o, 0);
    do_step();
    chk("R6", "ovf_d1", ovf_o, 1);
    chk("R6", "wrap_d1", val_o, 0);
  endtask

  task automatic t_sequence();
    do_load(32'd41, 32'd0, 32'd2);
    chk("R8", "f0", val_o, 41);
    for (int n = 1; n <= 1000; n++) begin
      do_step();
      chk("R8", "val", val_o, longint'(n) * n + n + 41);
      chk("R8", "idx", idx_o, n);
    end
    chk("R8", "ovf", ovf_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_idle();
    t_priority();
    t_overflow();
    t_sequence();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule